// File: doc/BRIEF.md
# Fan PWM Spin-Up and Ramp Stage

This stage drives one fan output. It takes the duty that an upstream lookup requests, or a manual duty when override is on, and turns it into the duty actually applied. It then generates a PWM waveform from that duty at a selectable output frequency.

Two behaviours change the applied duty. When the commanded duty leaves zero, a timed spin-up phase holds the output at no less than a configured floor, so that a stalled fan can start. When a bound processor-throttle or regulator-hot flag asserts, the duty climbs toward full scale in fixed increments, one increment per step time, instead of jumping at once. The applied duty is also brought out as a readback value.

Time is measured with an external `tick` pulse. Each tick stands for 50 ms.

Top module: `fan_spin_stage`

## Requirements
- R1: A spin-up phase starts only in the cycle in which the commanded duty goes from 0 to a nonzero value, and only when the spin-length code is nonzero. A change from one nonzero duty to another does not start a spin-up.
- R2: During spin-up the applied duty is the larger of the commanded duty and `spinMin`. Both use the same 8-bit encoding, in which 255 means 100%.
- R3: Spin-length codes 0 to 7 select 0, 2, 5, 8, 14, 20, 40 and 80 ticks, which is 0, 0.1, 0.25, 0.4, 0.7, 1.0, 2.0 and 4.0 s. Code 0 means no spin-up. Spin-up ends at the last tick of the selected length.
- R4: On a rising hot condition the ramp starts from the current base duty. The duty then rises by 16 every N ticks, where N is the smaller step code among the active sources (units of one tick, 0 to 15, that is 0 to 0.75 s). The duty saturates at 255.
- R5: While a bound hot source with step code 0 is active, the applied duty is 255 from the next cycle.
- R6: When the hot condition clears, the applied duty returns to the base duty in the next cycle.
- R7: When `manualEn` is 1, `manualDuty` replaces `reqDuty` as the commanded duty.
- R8: The PWM period has 255 slots, and the output is high while the slot index is below the applied duty. Duty 0 keeps the output always low, and duty 255 keeps it always high.
- R9: Frequency codes 0 to 7 select 12, 36, 48, 60, 72, 84 and 96 Hz and 22.5 kHz. Code 7 is the power-on choice of the register file. A slot lasts max(1, floor(CLK_HZ / (f * 255))) clocks.
- R10: `dutyNow` is registered and follows its inputs one clock later. After reset `dutyNow` is 0 and `pwmOut` is low.
- R11: A hot flag whose bind input is 0 has no effect on the duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse marking each 50 ms interval |
| reqDuty | input | 8 | Automatic duty request |
| hotThr | input | 1 | Processor throttle flag |
| hotVrd | input | 1 | Regulator-hot flag |
| bindThr | input | 1 | Lets the throttle flag drive the ramp |
| bindVrd | input | 1 | Lets the regulator-hot flag drive the ramp |
| manualEn | input | 1 | Selects the manual duty |
| manualDuty | input | 8 | Manual duty value |
| spinMin | input | 8 | Duty floor during spin-up |
| spinSel | input | 3 | Spin-length code |
| rampThrSel | input | 4 | Ramp step length for the throttle source, in ticks |
| rampVrdSel | input | 4 | Ramp step length for the regulator-hot source, in ticks |
| freqSel | input | 3 | Output frequency code |
| pwmOut | output | 1 | PWM waveform |
| dutyNow | output | 8 | Applied duty readback |

## Verification
The hardest states to reach are the end of a spin-up window and the saturation point of a ramp. Both are set by tick counts, not by clock cycles. The bench therefore generates `tick` itself, one pulse at a time, and samples the duty between pulses. This lets it see the last tick that still holds the floor and the first tick that releases it. It also walks a ramp from 64 through twelve increments into saturation. To check the slot length, the bench uses a small clock-rate parameter, so that it can count the high clocks over whole periods at three frequency codes.

// File: rtl/fan_spin_pkg.sv
package fan_spin_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic spinOn;    // spin-up floor applies
    logic rampOn;    // hot condition present
    logic rampLoad;  // first cycle of a hot condition
    logic rampFull;  // zero step time: go straight to full
    logic rampStep;  // one ramp increment due
  } fanCtrl_t;

  // Spin-up length in 50 ms ticks
  function automatic int unsigned spinTicks(input logic [2:0] sel);
    case (sel)
      3'd1: return 2;
      3'd2: return 5;
      3'd3: return 8;
      3'd4: return 14;
      3'd5: return 20;
      3'd6: return 40;
      3'd7: return 80;
      default: return 0;
    endcase
  endfunction

  // Output frequency in Hz
  function automatic int unsigned freqHz(input logic [2:0] sel);
    case (sel)
      3'd0: return 12;
      3'd1: return 36;
      3'd2: return 48;
      3'd3: return 60;
      3'd4: return 72;
      3'd5: return 84;
      3'd6: return 96;
      default: return 22500;
    endcase
  endfunction

endpackage

// File: rtl/fan_spin_ctrl.sv
module fan_spin_ctrl
  import fan_spin_pkg::*;
#(
  parameter int SPIN_W = 7,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              cmdZero,
  input  logic              hotThr,
  input  logic              hotVrd,
  input  logic              bindThr,
  input  logic              bindVrd,
  input  logic [2:0]        spinSel,
  input  logic [STEP_W-1:0] rampThrSel,
  input  logic [STEP_W-1:0] rampVrdSel,
  output fanCtrl_t          ctl
);

  logic              zeroPrev, hotPrev;
  logic [SPIN_W-1:0] spinCnt;
  logic [STEP_W-1:0] stepCnt, stepLen;
  logic              thrAct, vrdAct, hot, hotRise, spinStart, stepDue;

  assign thrAct = hotThr & bindThr;
  assign vrdAct = hotVrd & bindVrd;
  assign hot    = thrAct | vrdAct;
  assign hotRise = hot & ~hotPrev;

  // Shorter step time wins when both sources are active
  always_comb begin
    if (thrAct && vrdAct)
      stepLen = (rampThrSel < rampVrdSel) ? rampThrSel : rampVrdSel;
    else if (thrAct)
      stepLen = rampThrSel;
    else
      stepLen = rampVrdSel;
  end

  assign spinStart = zeroPrev & ~cmdZero & (spinSel != 3'd0);
  assign stepDue = hot & ~hotRise & tick & (stepLen != '0) &
                   ({1'b0, stepCnt} + 1'b1 >= {1'b0, stepLen});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zeroPrev <= 1'b1;
      hotPrev  <= 1'b0;
      spinCnt  <= '0;
      stepCnt  <= '0;
    end else begin
      zeroPrev <= cmdZero;
      hotPrev  <= hot;
      if (cmdZero)
        spinCnt <= '0;
      else if (spinStart)
        spinCnt <= SPIN_W'(spinTicks(spinSel));
      else if (tick && spinCnt != '0)
        spinCnt <= spinCnt - 1'b1;
      if (!hot || hotRise || stepDue)
        stepCnt <= '0;
      else if (tick && stepLen != '0)
        stepCnt <= stepCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.spinOn   = (spinCnt != '0) | spinStart;
    ctl.rampOn   = hot;
    ctl.rampLoad = hotRise;
    ctl.rampFull = hot & (stepLen == '0);
    ctl.rampStep = stepDue;
  end

endmodule

// File: rtl/fan_spin_dpath.sv
module fan_spin_dpath
  import fan_spin_pkg::*;
#(
  parameter int DUTY_W   = 8,
  parameter int STEP_INC = 16,
  parameter int CLK_HZ   = 50_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  fanCtrl_t          ctl,
  input  logic [DUTY_W-1:0] reqDuty,
  input  logic              manualEn,
  input  logic [DUTY_W-1:0] manualDuty,
  input  logic [DUTY_W-1:0] spinMin,
  input  logic [2:0]        freqSel,
  output logic              cmdZero,
  output logic              pwmOut,
  output logic [DUTY_W-1:0] dutyNow
);

  localparam int DUTY_MAX = (1 << DUTY_W) - 1;
  localparam int SLOT_MAX = CLK_HZ / (12 * DUTY_MAX);
  localparam int PRE_W    = $clog2(SLOT_MAX + 2);
  localparam logic [DUTY_W-1:0] FULL = DUTY_W'(DUTY_MAX);

  logic [DUTY_W-1:0] cmd, base, rampDuty, rampHeld, stepped, dutyNext;
  logic [DUTY_W:0]   sum;
  logic [PRE_W-1:0]  preCnt;
  logic [DUTY_W-1:0] slotIdx;
  int unsigned       slotLen, rawLen;

  assign cmd     = manualEn ? manualDuty : reqDuty;
  assign cmdZero = (cmd == '0);
  assign base    = (ctl.spinOn && spinMin > cmd) ? spinMin : cmd;
  assign sum     = {1'b0, rampDuty} + (DUTY_W + 1)'(STEP_INC);
  assign stepped = sum[DUTY_W] ? FULL : sum[DUTY_W-1:0];
  assign rampHeld = (rampDuty > base) ? rampDuty : base;

  always_comb begin
    if (!ctl.rampOn)       dutyNext = base;
    else if (ctl.rampFull) dutyNext = FULL;
    else if (ctl.rampLoad) dutyNext = base;
    else                   dutyNext = rampHeld;
  end

  always_comb begin
    rawLen  = CLK_HZ / (freqHz(freqSel) * DUTY_MAX);
    slotLen = (rawLen == 0) ? 1 : rawLen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rampDuty <= '0;
      dutyNow  <= '0;
      preCnt   <= '0;
      slotIdx  <= '0;
    end else begin
      dutyNow <= dutyNext;
      if (ctl.rampFull)      rampDuty <= FULL;
      else if (ctl.rampLoad) rampDuty <= base;
      else if (ctl.rampStep) rampDuty <= stepped;
      if (32'(preCnt) + 1 >= slotLen) begin
        preCnt  <= '0;
        slotIdx <= (slotIdx >= FULL - 1'b1) ? '0 : slotIdx + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  assign pwmOut = (slotIdx < dutyNow);

endmodule

// File: rtl/fan_spin_stage.sv
module fan_spin_stage
  import fan_spin_pkg::*;
#(
  parameter int DUTY_W   = 8,
  parameter int STEP_W   = 4,
  parameter int SPIN_W   = 7,
  parameter int STEP_INC = 16,
  parameter int CLK_HZ   = 50_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [DUTY_W-1:0] reqDuty,
  input  logic              hotThr,
  input  logic              hotVrd,
  input  logic              bindThr,
  input  logic              bindVrd,
  input  logic              manualEn,
  input  logic [DUTY_W-1:0] manualDuty,
  input  logic [DUTY_W-1:0] spinMin,
  input  logic [2:0]        spinSel,
  input  logic [STEP_W-1:0] rampThrSel,
  input  logic [STEP_W-1:0] rampVrdSel,
  input  logic [2:0]        freqSel,
  output logic              pwmOut,
  output logic [DUTY_W-1:0] dutyNow
);

  fanCtrl_t ctlBus;
  logic     cmdZero;

  fan_spin_ctrl #(.SPIN_W(SPIN_W), .STEP_W(STEP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .cmdZero(cmdZero),
    .hotThr(hotThr), .hotVrd(hotVrd), .bindThr(bindThr), .bindVrd(bindVrd),
    .spinSel(spinSel), .rampThrSel(rampThrSel), .rampVrdSel(rampVrdSel),
    .ctl(ctlBus)
  );

  fan_spin_dpath #(.DUTY_W(DUTY_W), .STEP_INC(STEP_INC), .CLK_HZ(CLK_HZ)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctlBus), .reqDuty(reqDuty),
    .manualEn(manualEn), .manualDuty(manualDuty), .spinMin(spinMin),
    .freqSel(freqSel), .cmdZero(cmdZero), .pwmOut(pwmOut), .dutyNow(dutyNow)
  );

endmodule

// File: rtl/fan_spin_checker.sv
module fan_spin_checker
  import fan_spin_pkg::*;
#(
  parameter int DUTY_W = 8,
  parameter int STEP_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [DUTY_W-1:0] reqDuty,
  input logic              hotThr,
  input logic              hotVrd,
  input logic              bindThr,
  input logic              bindVrd,
  input logic              manualEn,
  input logic [DUTY_W-1:0] manualDuty,
  input logic [DUTY_W-1:0] spinMin,
  input logic [2:0]        spinSel,
  input logic [STEP_W-1:0] rampThrSel,
  input logic              pwmOut,
  input logic [DUTY_W-1:0] dutyNow,
  input fanCtrl_t          ctl
);

  logic              hotAny;
  logic [DUTY_W-1:0] cmdSeen;
  assign hotAny  = (hotThr & bindThr) | (hotVrd & bindVrd);
  assign cmdSeen = manualEn ? manualDuty : reqDuty;

  p_spin_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.spinOn) |-> (spinSel != 3'd0 && cmdSeen != '0));

  p_spin_floor_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.spinOn |=> dutyNow >= $past(spinMin));

  p_jump_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hotThr && bindThr && rampThrSel == '0) |=> dutyNow == '1);

  // covers R7 as well: the base duty follows the override selection
  p_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!hotAny && !ctl.spinOn) |=> dutyNow == $past(cmdSeen));

  p_pwm_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    dutyNow == '0 |-> !pwmOut);

  p_pwm_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    dutyNow == '1 |-> pwmOut);

endmodule

bind fan_spin_stage fan_spin_checker #(.DUTY_W(DUTY_W), .STEP_W(STEP_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqDuty(reqDuty), .hotThr(hotThr), .hotVrd(hotVrd),
  .bindThr(bindThr), .bindVrd(bindVrd), .manualEn(manualEn),
  .manualDuty(manualDuty), .spinMin(spinMin), .spinSel(spinSel),
  .rampThrSel(rampThrSel), .pwmOut(pwmOut), .dutyNow(dutyNow), .ctl(ctlBus)
);

// File: tb/test_fan_spin_stage.sv
module test_fan_spin_stage;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] reqDuty = '0, manualDuty = '0, spinMin = '0;
  logic       hotThr = 0, hotVrd = 0, bindThr = 0, bindVrd = 0, manualEn = 0;
  logic [2:0] spinSel = '0, freqSel = 3'd7;
  logic [3:0] rampThrSel = '0, rampVrdSel = '0;
  logic       pwmOut;
  logic [7:0] dutyNow;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fan_spin_stage #(.CLK_HZ(1_000_000)) i_fan_spin_stage (
    .clk(clk), .rstN(rstN), .tick(tick), .reqDuty(reqDuty),
    .hotThr(hotThr), .hotVrd(hotVrd), .bindThr(bindThr), .bindVrd(bindVrd),
    .manualEn(manualEn), .manualDuty(manualDuty), .spinMin(spinMin),
    .spinSel(spinSel), .rampThrSel(rampThrSel), .rampVrdSel(rampVrdSel),
    .freqSel(freqSel), .pwmOut(pwmOut), .dutyNow(dutyNow)
  );

  // {manualEn, manualDuty, reqDuty, expected duty}
  localparam logic [24:0] VEC [6] = '{
    {1'b0, 8'd0,   8'd40,  8'd40},
    {1'b0, 8'd200, 8'd90,  8'd90},
    {1'b1, 8'd200, 8'd90,  8'd200},
    {1'b1, 8'd0,   8'd90,  8'd0},
    {1'b1, 8'd255, 8'd0,   8'd255},
    {1'b0, 8'd255, 8'd17,  8'd17}
  };

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse();
    tick = 1'b1; cyc(1); tick = 1'b0; cyc(1);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic countHigh(input int n, output int h);
    h = 0;
    repeat (n) begin
      @(posedge clk); #1;
      if (pwmOut) h++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int h;
    cyc(3);
    chk("R10 reset duty", dutyNow, 0);
    chk("R10 reset pwm", pwmOut, 0);
    rstN = 1'b1;
    cyc(2);

    // R7 table walk: override selection, no spin, no hot
    foreach (VEC[i]) begin
      manualEn = VEC[i][24]; manualDuty = VEC[i][23:16]; reqDuty = VEC[i][15:8];
      cyc(1);
      chk("R7 table", dutyNow, int'(VEC[i][7:0]));
    end
    manualEn = 0;

    // R1/R2/R3 spin-up, code 2 = 5 ticks
    reqDuty = 0; cyc(2);
    spinSel = 3'd2; spinMin = 8'd100; reqDuty = 8'd30; cyc(1);
    chk("R2 spin floor", dutyNow, 100);
    repeat (4) pulse();
    chk("R3 spin held at 4 ticks", dutyNow, 100);
    pulse();
    chk("R3 spin ends at 5 ticks", dutyNow, 30);
    reqDuty = 8'd50; cyc(1);
    chk("R1 nonzero change no spin", dutyNow, 50);
    reqDuty = 0; cyc(2); reqDuty = 8'd150; cyc(1);
    chk("R2 cmd above floor", dutyNow, 150);
    reqDuty = 0; cyc(2); spinSel = 3'd0; reqDuty = 8'd30; cyc(1);
    chk("R3 code 0 no spin", dutyNow, 30);

    // R4 ramp from 64 with step 2 ticks
    reqDuty = 8'd64; cyc(2);
    bindThr = 1; rampThrSel = 4'd2; rampVrdSel = 4'd5;
    hotThr = 1; cyc(1);
    chk("R4 ramp start", dutyNow, 64);
    pulse();
    chk("R4 before first step", dutyNow, 64);
    pulse();
    chk("R4 first step", dutyNow, 80);
    repeat (20) pulse();
    chk("R4 eleven steps", dutyNow, 240);
    repeat (2) pulse();
    chk("R4 saturate", dutyNow, 255);
    hotThr = 0; cyc(1);
    chk("R6 release", dutyNow, 64);

    // R4 two sources: shorter step wins
    bindVrd = 1; rampThrSel = 4'd6; rampVrdSel = 4'd3;
    hotThr = 1; hotVrd = 1; cyc(1);
    repeat (3) pulse();
    chk("R4 min step length", dutyNow, 80);
    hotThr = 0; hotVrd = 0; bindVrd = 0; cyc(1);

    // R5 zero step time
    rampThrSel = 4'd0; hotThr = 1; cyc(1);
    chk("R5 jump full", dutyNow, 255);
    hotThr = 0; cyc(1);
    chk("R6 release after jump", dutyNow, 64);

    // R11 unbound flag ignored
    bindThr = 0; rampThrSel = 4'd0; hotThr = 1; hotVrd = 1; cyc(1);
    repeat (3) pulse();
    chk("R11 unbound", dutyNow, 64);
    hotThr = 0; hotVrd = 0;

    // R8 waveform at 22.5 kHz (slot = 1 clock here)
    reqDuty = 8'd128; cyc(300);
    countHigh(255, h); chk("R8 duty 128", h, 128);
    reqDuty = 8'd0; cyc(2);
    countHigh(255, h); chk("R8 duty 0", h, 0);
    reqDuty = 8'd255; cyc(2);
    countHigh(255, h); chk("R8 duty 255", h, 255);

    // R9 frequency codes 6 (slot 40) and 3 (slot 65)
    reqDuty = 8'd128; freqSel = 3'd6; cyc(10300);
    countHigh(10200, h); chk("R9 96 Hz", h, 5120);
    reqDuty = 8'd64; freqSel = 3'd3; cyc(16700);
    countHigh(16575, h); chk("R9 60 Hz", h, 4160);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule